// File: doc/BRIEF.md
# Composed 36x36 Partial-Product Multiplier

This block multiplies two 36-bit operands and returns the exact 72-bit product. It builds that product from four 18x18 sub-products. Each operand is cut into a low half and a high half. Every pairing of halves is multiplied, and the four results are weighted and summed in a dedicated summation stage.

A separate sign input for each operand selects two's complement or unsigned treatment at run time. The sign inputs travel through the input registers together with the data.

Latency is a build-time choice of 1, 2 or 3 register stages. The input registers are always present. A pipeline register between the sub-multipliers and the summation stage is optional, and so is a register on the result. All stages share one clock enable and one asynchronous clear.

Top module: `composed_mul36`

## Requirements
- R1: With both sign inputs low, `product` equals the unsigned product of the two operands. Each operand is read as a 36-bit unsigned number, and all 72 bits of the result are kept.
- R2: With `sign_a` high and `sign_b` low, operand A is read as two's complement and operand B as unsigned. `product` holds the 72-bit two's complement result.
- R3: With `sign_a` low and `sign_b` high, operand B is read as two's complement and operand A as unsigned. `product` holds the 72-bit two's complement result.
- R4: With both sign inputs high, both operands are two's complement and the 72-bit result is exact.
- R5: Operands presented with `ce` high at rising edge k appear on `product` after rising edge k+LATENCY-1. With LATENCY=1 only the input registers are used. LATENCY=2 adds the register after the sub-multipliers, and LATENCY=3 adds the output register.
- R6: While `ce` is low, no register changes. `product` keeps its value even if the operands and sign inputs change.
- R7: Raising `clear` drives `product` to zero at once, without a clock edge, and keeps it there while `clear` stays high.
- R8: The sign inputs are captured together with the operands. A sign change on the next cycle does not alter a product already in flight.
- R9: Corner operands give exact results:
  - all ones unsigned squared is (2^36-1)^2;
  - the most negative value squared, signed, is 2^70;
  - all ones as signed (that is, -1) times the most negative value is 2^35;
  - any operand of zero gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous clear of every register, active high |
| ce | input | 1 | Clock enable shared by all register stages |
| op_a | input | OPW | Operand A |
| sign_a | input | 1 | High: operand A is two's complement |
| op_b | input | OPW | Operand B |
| sign_b | input | 1 | High: operand B is two's complement |
| product | output | 2*OPW | Full-precision product |

## Verification
The bench builds three copies with OPW=36 and LATENCY set to 1, 2 and 3, and drives all three from one stimulus stream. Each copy expects each result at its own offset. This exposes a missing or extra stage, and any stage that ignores the clock enable or the clear. The stream covers all four sign combinations over operands that straddle the half boundary: all ones, the most negative value, zero, and bit patterns at bits 17 and 18. Those operands load each cross product's sign extension.

// File: rtl/cm36_pkg.sv
package cm36_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } sign_pair_t;

    // Weight of sub-product idx: bit 0 picks the high half of A,
    // bit 1 picks the high half of B.
    function automatic int pp_shift(input int idx, input int hw);
        return ((idx & 1) + ((idx >> 1) & 1)) * hw;
    endfunction

endpackage

// File: rtl/cm36_in_stage.sv
module cm36_in_stage
    import cm36_pkg::*;
#(
    parameter int OPW = 36
) (
    input  logic           clk,
    input  logic           clear,
    input  logic           ce,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    input  sign_pair_t     sgn_in,
    output logic [OPW-1:0] a_q,
    output logic [OPW-1:0] b_q,
    output sign_pair_t     sgn_q
);

    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= '0;
        end else if (ce) begin
            a_q   <= a_in;
            b_q   <= b_in;
            sgn_q <= sgn_in;
        end
    end

endmodule

// File: rtl/cm36_part_mult.sv
module cm36_part_mult #(
    parameter int EW = 19
) (
    input  logic [EW-1:0]   x,
    input  logic [EW-1:0]   y,
    output logic [2*EW-1:0] p
);

    assign p = $signed(x) * $signed(y);

endmodule

// File: rtl/cm36_opt_reg.sv
module cm36_opt_reg #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (ENABLE) begin : g_reg
        always_ff @(posedge clk or posedge clear) begin
            if (clear)   q <= '0;
            else if (ce) q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end

endmodule

// File: rtl/cm36_sum.sv
module cm36_sum
    import cm36_pkg::*;
#(
    parameter int HW = 18
) (
    input  logic [4*(2*HW+2)-1:0] pp_flat,
    output logic [4*HW-1:0]       total
);

    localparam int EW  = HW + 1;
    localparam int PPW = 2 * EW;
    localparam int RW  = 4 * HW;

    logic [RW-1:0] term [4];

    for (genvar i = 0; i < 4; i++) begin : g_term
        logic [PPW-1:0] pp;
        logic [RW-1:0]  wide;
        assign pp      = pp_flat[i*PPW +: PPW];
        assign wide    = {{(RW-PPW){pp[PPW-1]}}, pp};
        assign term[i] = wide << pp_shift(i, HW);
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < 4; i++) total = total + term[i];
    end

endmodule

// File: rtl/composed_mul36.sv
module composed_mul36
    import cm36_pkg::*;
#(
    parameter int OPW     = 36,
    parameter int LATENCY = 3
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             ce,
    input  logic [OPW-1:0]   op_a,
    input  logic             sign_a,
    input  logic [OPW-1:0]   op_b,
    input  logic             sign_b,
    output logic [2*OPW-1:0] product
);

    localparam int HW       = OPW / 2;
    localparam int EW       = HW + 1;
    localparam int PPW      = 2 * EW;
    localparam int RW       = 2 * OPW;
    localparam bit USE_PIPE = (LATENCY >= 2);
    localparam bit USE_OUT  = (LATENCY >= 3);

    logic [OPW-1:0] a_q, b_q;
    sign_pair_t     sgn_q;

    cm36_in_stage #(.OPW(OPW)) u_in (
        .clk    (clk),
        .clear  (clear),
        .ce     (ce),
        .a_in   (op_a),
        .b_in   (op_b),
        .sgn_in ('{a: sign_a, b: sign_b}),
        .a_q    (a_q),
        .b_q    (b_q),
        .sgn_q  (sgn_q)
    );

    // Low halves are zero-extended.  A high half is sign-extended only
    // when its operand is marked signed.
    logic [EW-1:0] a_half [2];
    logic [EW-1:0] b_half [2];

    assign a_half[0] = {1'b0, a_q[HW-1:0]};
    assign a_half[1] = {sgn_q.a & a_q[OPW-1], a_q[OPW-1:HW]};
    assign b_half[0] = {1'b0, b_q[HW-1:0]};
    assign b_half[1] = {sgn_q.b & b_q[OPW-1], b_q[OPW-1:HW]};

    logic [4*PPW-1:0] pp_raw, pp_stage;

    for (genvar i = 0; i < 4; i++) begin : g_pp
        cm36_part_mult #(.EW(EW)) u_pm (
            .x (a_half[i % 2]),
            .y (b_half[i / 2]),
            .p (pp_raw[i*PPW +: PPW])
        );
    end

    cm36_opt_reg #(.W(4*PPW), .ENABLE(USE_PIPE)) u_pipe (
        .clk   (clk),
        .clear (clear),
        .ce    (ce),
        .d     (pp_raw),
        .q     (pp_stage)
    );

    logic [RW-1:0] sum_out;

    cm36_sum #(.HW(HW)) u_sum (
        .pp_flat (pp_stage),
        .total   (sum_out)
    );

    cm36_opt_reg #(.W(RW), .ENABLE(USE_OUT)) u_out (
        .clk   (clk),
        .clear (clear),
        .ce    (ce),
        .d     (sum_out),
        .q     (product)
    );

endmodule

// File: rtl/cm36_chk.sv
module cm36_chk #(
    parameter int OPW     = 36,
    parameter int LATENCY = 3
) (
    input logic             clk,
    input logic             clear,
    input logic             ce,
    input logic [OPW-1:0]   op_a,
    input logic             sign_a,
    input logic [OPW-1:0]   op_b,
    input logic             sign_b,
    input logic [2*OPW-1:0] product
);

    localparam int RW = 2 * OPW;

    logic [RW-1:0] ea, eb, full;
    assign ea   = {{OPW{sign_a & op_a[OPW-1]}}, op_a};
    assign eb   = {{OPW{sign_b & op_b[OPW-1]}}, op_b};
    assign full = ea * eb;

    logic [RW-1:0] ref_pipe  [3];
    logic          zero_pipe [3];

    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            for (int i = 0; i < 3; i++) begin
                ref_pipe[i]  <= '0;
                zero_pipe[i] <= 1'b1;
            end
        end else if (ce) begin
            ref_pipe[0]  <= full;
            zero_pipe[0] <= (op_a == '0) || (op_b == '0);
            for (int i = 1; i < 3; i++) begin
                ref_pipe[i]  <= ref_pipe[i-1];
                zero_pipe[i] <= zero_pipe[i-1];
            end
        end
    end

    // R5
    product_match_chk: assert property (@(posedge clk) disable iff (clear)
        product == ref_pipe[LATENCY-1]);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (clear)
        !ce |=> $stable(product));

    // R9
    zero_operand_chk: assert property (@(posedge clk) disable iff (clear)
        zero_pipe[LATENCY-1] |-> (product == '0));

    // R7
    always @(negedge clk) begin
        if (clear) begin
            clear_zero_chk: assert (product == '0);
        end
    end

endmodule

bind composed_mul36 cm36_chk #(.OPW(OPW), .LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .clear   (clear),
    .ce      (ce),
    .op_a    (op_a),
    .sign_a  (sign_a),
    .op_b    (op_b),
    .sign_b  (sign_b),
    .product (product)
);

// File: tb/tb_composed_mul36.sv
`timescale 1ns/1ps
module tb_composed_mul36;

    typedef struct {
        int          due;
        logic [71:0] exp;
        int          req;
    } item_t;

    logic        clk = 1'b0;
    logic        clear = 1'b1;
    logic        ce = 1'b0;
    logic [35:0] op_a = '0, op_b = '0;
    logic        sign_a = 1'b0, sign_b = 1'b0;
    logic [71:0] res1, res2, res3;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    item_t q1[$], q2[$], q3[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    composed_mul36 #(.OPW(36), .LATENCY(1)) dut_l1 (
        .clk(clk), .clear(clear), .ce(ce), .op_a(op_a), .sign_a(sign_a),
        .op_b(op_b), .sign_b(sign_b), .product(res1));
    composed_mul36 #(.OPW(36), .LATENCY(2)) dut_l2 (
        .clk(clk), .clear(clear), .ce(ce), .op_a(op_a), .sign_a(sign_a),
        .op_b(op_b), .sign_b(sign_b), .product(res2));
    composed_mul36 #(.OPW(36), .LATENCY(3)) dut (
        .clk(clk), .clear(clear), .ce(ce), .op_a(op_a), .sign_a(sign_a),
        .op_b(op_b), .sign_b(sign_b), .product(res3));

    function automatic logic [71:0] ref_prod(input logic [35:0] a, input logic [35:0] b,
                                             input logic sa, input logic sb);
        logic [71:0] ea, eb;
        ea = {{36{sa & a[35]}}, a};
        eb = {{36{sb & b[35]}}, b};
        return ea * eb;
    endfunction

    task automatic check(input logic [71:0] act, input logic [71:0] exp,
                         input int req, input int lat);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d latency=%0d actual=%h expected=%h", req, lat, act, exp);
        end
    endtask

    // Driver: present one operand pair and queue its expected result.
    task automatic push(input logic [35:0] a, input logic [35:0] b,
                        input logic sa, input logic sb, input int req);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; sign_a = sa; sign_b = sb; ce = 1'b1;
        it.exp = ref_prod(a, b, sa, sb);
        it.req = req;
        it.due = cyc + 1; q1.push_back(it);
        it.due = cyc + 2; q2.push_back(it);
        it.due = cyc + 3; q3.push_back(it);
    endtask

    // Monitor: compare each result in the cycle it is due.
    always @(negedge clk) begin : monitor
        item_t it;
        if (q1.size() > 0 && q1[0].due == cyc) begin it = q1.pop_front(); check(res1, it.exp, it.req, 1); end
        if (q2.size() > 0 && q2[0].due == cyc) begin it = q2.pop_front(); check(res2, it.exp, it.req, 2); end
        if (q3.size() > 0 && q3[0].due == cyc) begin it = q3.pop_front(); check(res3, it.exp, it.req, 3); end
    end

    logic [35:0] vals [8];
    initial begin
        vals[0] = 36'hFFFFFFFFF;
        vals[1] = 36'h800000000;
        vals[2] = 36'h000000000;
        vals[3] = 36'h000000001;
        vals[4] = 36'h00003FFFF;
        vals[5] = 36'h000040000;
        vals[6] = 36'h7FFFFFFFF;
        vals[7] = 36'hA5C3E1B97;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [71:0] hold_val;
        #12;
        // R7 reset state
        check(res1, 72'd0, 7, 1);
        check(res2, 72'd0, 7, 2);
        check(res3, 72'd0, 7, 3);
        @(negedge clk);
        clear = 1'b0;

        // R1 R2 R3 R4: all sign combinations over boundary operands
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    push(vals[i], vals[j], s[0], s[1],
                         (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 3 : 4);
                end
            end
        end

        // R9 corner values with explicit expectations
        push(36'hFFFFFFFFF, 36'hFFFFFFFFF, 1'b0, 1'b0, 9);
        push(36'h800000000, 36'h800000000, 1'b1, 1'b1, 9);
        push(36'hFFFFFFFFF, 36'h800000000, 1'b1, 1'b1, 9);
        push(36'h000000000, 36'hFFFFFFFFF, 1'b1, 1'b0, 9);
        repeat (4) @(negedge clk);
        if (ref_prod(36'h800000000, 36'h800000000, 1'b1, 1'b1) != (72'd1 << 70)) begin
            errors++;
            $display("FAIL R9 bench reference inconsistent");
        end

        // R8: sign flips on consecutive cycles with the same operands
        push(36'hFFFFFFFFF, 36'h800000000, 1'b1, 1'b0, 8);
        push(36'hFFFFFFFFF, 36'h800000000, 1'b0, 1'b1, 8);
        push(36'hFFFFFFFFF, 36'h800000000, 1'b0, 1'b0, 8);
        push(36'hFFFFFFFFF, 36'h800000000, 1'b1, 1'b1, 8);

        // R5: one lone product between zeros shows each latency
        for (int k = 0; k < 3; k++) push(36'd0, 36'd0, 1'b0, 1'b0, 5);
        push(36'h123456789, 36'h0FEDCBA98, 1'b1, 1'b0, 5);
        for (int k = 0; k < 3; k++) push(36'd0, 36'd0, 1'b0, 1'b0, 5);

        // R6: load a value, then hold with ce low while inputs change
        for (int k = 0; k < 4; k++) push(36'h00003FFFF, 36'h800000001, 1'b0, 1'b1, 6);
        repeat (3) @(negedge clk);
        hold_val = ref_prod(36'h00003FFFF, 36'h800000001, 1'b0, 1'b1);
        ce = 1'b0;
        op_a = 36'hFFFFFFFFF; op_b = 36'h7FFFFFFFF; sign_a = 1'b1; sign_b = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(res1, hold_val, 6, 1);
            check(res2, hold_val, 6, 2);
            check(res3, hold_val, 6, 3);
        end

        // R7: asynchronous clear between edges
        for (int k = 0; k < 4; k++) push(36'h555555555, 36'h333333333, 1'b0, 1'b0, 7);
        repeat (3) @(negedge clk);
        #0.5 clear = 1'b1;
        #0.5;
        check(res1, 72'd0, 7, 1);
        check(res2, 72'd0, 7, 2);
        check(res3, 72'd0, 7, 3);
        @(negedge clk);
        clear = 1'b0;
        ce = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule